// File: doc/BRIEF.md
# Single-Commit Seeded LFSR with Serial Seed Port

This block produces a 24-bit pseudo-random word from a Fibonacci linear feedback shift register that runs on the local bus clock. At reset the register starts from a fixed built-in constant. An external controller can replace that start value once. It shifts a 24-bit seed in over a simple SPI slave port that has its own clock, and then pulses a load strobe. After that single commit, a sticky lock flag refuses every later seeding attempt until the next reset.

The seed never reaches the load multiplexer straight from the SPI clock domain. When the SPI receiver completes a 24-bit frame, it flips a frame toggle. That toggle is synchronized into the LFSR clock domain, and only a change of the synchronized toggle copies the finished word into a capture register. The load multiplexer reads this capture register. The load strobe is synchronized and edge-detected in the same way, and a small state machine turns one rising edge into exactly one load cycle. The register advances only on cycles where a registered copy of the step enable input is high.

The controller state machine has three states. ST_OPEN is the state after reset: the LFSR holds or steps from the constant, and a rising edge of the load strobe moves to ST_COMMIT. ST_COMMIT lasts one cycle: the load is issued and the machine always moves on to ST_SEALED. ST_SEALED has no exit transition: the lock flag is high and load strobes are ignored. Only reset returns the machine to ST_OPEN.

Top module: `seed_lock_lfsr`

## Requirements
- R1: After reset the output word equals the built-in constant 24'h5A3C96 and the lock flag is 0.
- R2: With chip-select low, the SPI slave samples the data pin on each rising serial clock edge, most significant bit first. The 24th bit completes the frame word.
- R3: The first rising edge of the load strobe after reset copies the captured SPI word into the LFSR and sets the lock flag. No stepping happens while the step enable is low.
- R4: A captured word of all zeros is replaced by the built-in constant when loaded, so the output word is never zero.
- R5: The LFSR advances once per clock for each cycle in which the one-cycle-registered step enable is high, and holds otherwise. The next value is {s[22:0], s[23]^s[22]^s[21]^s[16]}.
- R6: Once the lock flag is set, further rising edges of the load strobe leave the output word unchanged.
- R7: Once the lock flag is set, shifting a new SPI frame in leaves the output word unchanged.
- R8: When the load cycle and an enabled step fall on the same clock, the load wins, and stepping continues from the loaded seed on the following clocks.
- R9: The lock flag stays high from the load until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LFSR domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| spi_clk | input | 1 | SPI serial clock from the controller |
| spi_cs_n | input | 1 | SPI chip-select, active low |
| spi_mosi | input | 1 | SPI serial data in, MSB first |
| load_req | input | 1 | Asynchronous seed commit strobe |
| step_en | input | 1 | Step enable, registered once before use |
| lfsr_word | output | 24 | Current LFSR state |
| locked | output | 1 | Sticky flag: the seed has been committed |

## Verification
The functions that can meet on one clock are the seed commit and an enabled step. The bench holds the step enable high continuously while it raises the load strobe, so the load cycle arrives three clocks after the strobe is first registered and lands on a stepping clock. It then checks that the word on the following clock is exactly the SPI seed, and that after three more clocks it is that seed advanced three times. Any leaked step, or a step applied on top of the load, shows up as a different word.

// File: rtl/slf_pkg.sv
package slf_pkg;

    typedef enum logic [1:0] {
        ST_OPEN   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_SEALED = 2'd2
    } seal_state_t;

    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/slf_sync.sv
module slf_sync #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    import slf_pkg::*;

    logic [WIDTH-1:0] stage_q [SYNC_STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_o = stage_q[SYNC_STAGES-1];

endmodule

// File: rtl/slf_spi_rx.sv
module slf_spi_rx #(
    parameter int unsigned W = 24
) (
    input  logic         spi_clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         mosi,
    output logic [W-1:0] word_o,
    output logic         frame_tgl_o
);
    localparam int unsigned CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

    logic [W-1:0]     shreg_q;
    logic [W-1:0]     shreg_nx;
    logic [CNT_W-1:0] bit_cnt_q;

    assign shreg_nx = {shreg_q[W-2:0], mosi};

    always_ff @(posedge spi_clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q     <= '0;
            bit_cnt_q   <= '0;
            word_o      <= '0;
            frame_tgl_o <= 1'b0;
        end else if (cs_n) begin
            bit_cnt_q <= '0;
        end else begin
            shreg_q <= shreg_nx;
            if (bit_cnt_q == LAST_BIT) begin
                bit_cnt_q   <= '0;
                word_o      <= shreg_nx;
                frame_tgl_o <= ~frame_tgl_o;
            end else begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge spi_clk) disable iff (!rst_n)
        bit_cnt_q <= LAST_BIT); // R2

    AST_TGL_ON_FULL: assert property (@(posedge spi_clk) disable iff (!rst_n)
        (!cs_n && bit_cnt_q != LAST_BIT) |=> $stable(frame_tgl_o)); // R2

endmodule

// File: rtl/slf_ctrl.sv
module slf_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_sync_i,
    output logic load_o,
    output logic locked_o
);
    import slf_pkg::*;

    seal_state_t state_q, state_nx;
    logic        strobe_prev_q;
    logic        strobe_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_prev_q <= 1'b0;
        else        strobe_prev_q <= strobe_sync_i;
    end

    assign strobe_rise = strobe_sync_i & ~strobe_prev_q;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_OPEN:   if (strobe_rise) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_SEALED;
            ST_SEALED: state_nx = ST_SEALED;
            default:   state_nx = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_nx;
    end

    always_comb begin
        load_o   = 1'b0;
        locked_o = 1'b0;
        unique case (state_q)
            ST_OPEN:   ;
            ST_COMMIT: load_o = 1'b1;
            ST_SEALED: locked_o = 1'b1;
            default:   ;
        endcase
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> locked_o); // R9

    AST_LOCK_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(load_o)); // R3

    AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o); // R6

endmodule

// File: rtl/slf_lfsr.sv
module slf_lfsr #(
    parameter int unsigned   W    = 24,
    parameter logic [W-1:0]  INIT = 24'h5A3C96,
    parameter logic [W-1:0]  TAPS = 24'hE10000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] seed_i,
    input  logic         step_i,
    output logic [W-1:0] state_o
);
    logic [W-1:0] state_q;
    logic         feedback;

    assign feedback = ^(state_q & TAPS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state_q <= INIT;
        else if (load_i) state_q <= seed_i;
        else if (step_i) state_q <= {state_q[W-2:0], feedback};
    end

    assign state_o = state_q;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(state_q)); // R5

    AST_LOAD_TAKES_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> state_q == $past(seed_i)); // R8

    AST_STEP_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> state_q[W-1:1] == $past(state_q[W-2:0])); // R5

endmodule

// File: rtl/seed_lock_lfsr.sv
module seed_lock_lfsr #(
    parameter int unsigned  W    = 24,
    parameter logic [W-1:0] INIT = 24'h5A3C96,
    parameter logic [W-1:0] TAPS = 24'hE10000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         spi_clk,
    input  logic         spi_cs_n,
    input  logic         spi_mosi,
    input  logic         load_req,
    input  logic         step_en,
    output logic [W-1:0] lfsr_word,
    output logic         locked
);
    logic [W-1:0] spi_word;
    logic         spi_tgl;
    logic [1:0]   sync_in;
    logic [1:0]   sync_out;
    logic         tgl_sync, strobe_sync;
    logic         tgl_prev_q;
    logic [W-1:0] capture_q;
    logic [W-1:0] seed_mux;
    logic         step_q;
    logic         load_now;

    slf_spi_rx #(.W(W)) i_spi_rx (
        .spi_clk    (spi_clk),
        .rst_n      (rst_n),
        .cs_n       (spi_cs_n),
        .mosi       (spi_mosi),
        .word_o     (spi_word),
        .frame_tgl_o(spi_tgl)
    );

    assign sync_in = {load_req, spi_tgl};

    slf_sync #(.WIDTH(2)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(sync_in),
        .sync_o (sync_out)
    );

    assign tgl_sync    = sync_out[0];
    assign strobe_sync = sync_out[1];

    // Capture register: the word is quasi-static once its toggle is seen.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgl_prev_q <= 1'b0;
            capture_q  <= '0;
        end else begin
            tgl_prev_q <= tgl_sync;
            if (tgl_sync != tgl_prev_q) capture_q <= spi_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step_q <= 1'b0;
        else        step_q <= step_en;
    end

    slf_ctrl i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_sync_i(strobe_sync),
        .load_o       (load_now),
        .locked_o     (locked)
    );

    assign seed_mux = (capture_q == '0) ? INIT : capture_q;

    slf_lfsr #(.W(W), .INIT(INIT), .TAPS(TAPS)) i_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_now),
        .seed_i (seed_mux),
        .step_i (step_q),
        .state_o(lfsr_word)
    );

    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_word != '0); // R4

    AST_SEALED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !step_q) |=> $stable(lfsr_word)); // R7

endmodule

// File: tb/test_seed_lock_lfsr.sv
module test_seed_lock_lfsr;

    localparam logic [23:0] CONST_SEED = 24'h5A3C96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_clk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        load_req = 1'b0;
    logic        step_en = 1'b0;
    logic [23:0] lfsr_word;
    logic        locked;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    seed_lock_lfsr i_seed_lock_lfsr (
        .clk(clk), .rst_n(rst_n), .spi_clk(spi_clk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .load_req(load_req), .step_en(step_en),
        .lfsr_word(lfsr_word), .locked(locked)
    );

    // seed (upper 24 bits) and step count (lower 24 bits)
    localparam logic [47:0] VEC [5] = '{
        {24'h123456, 24'd5},
        {24'h800001, 24'd17},
        {24'h000000, 24'd9},
        {24'hF0F0F0, 24'd0},
        {24'h00C3A5, 24'd40}
    };

    function automatic logic [23:0] adv(input logic [23:0] s, input int n);
        logic [23:0] v = s;
        for (int i = 0; i < n; i++) v = {v[22:0], v[23] ^ v[22] ^ v[21] ^ v[16]};
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [23:0] act,
                         input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; load_req = 1'b0; step_en = 1'b0; spi_cs_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic spi_send(input logic [23:0] w);
        spi_cs_n = 1'b0;
        #7;
        for (int b = 23; b >= 0; b--) begin
            spi_mosi = w[b];
            #15 spi_clk = 1'b1;
            #15 spi_clk = 1'b0;
        end
        #7 spi_cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse_load();
        @(negedge clk) load_req = 1'b1;
        repeat (4) @(negedge clk);
        load_req = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_steps(input int n);
        if (n > 0) begin
            @(negedge clk) step_en = 1'b1;
            repeat (n) @(negedge clk);
            step_en = 1'b0;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [23:0] exp, held;

        // Table walk: one reset, seed, commit and step run per row.
        for (int r = 0; r < 5; r++) begin
            logic [23:0] sd = VEC[r][47:24];
            int          ns = int'(VEC[r][23:0]);
            do_reset();
            check(lfsr_word == CONST_SEED, "R1 reset word", lfsr_word, CONST_SEED);
            check(locked == 1'b0, "R1 reset lock", {23'd0, locked}, 24'd0);
            spi_send(sd);
            check(lfsr_word == CONST_SEED, "R3 no load before strobe", lfsr_word, CONST_SEED);
            pulse_load();
            exp = (sd == 24'd0) ? CONST_SEED : sd;
            check(lfsr_word == exp, "R2 R3 R4 committed seed", lfsr_word, exp);
            check(locked == 1'b1, "R3 lock set", {23'd0, locked}, 24'd1);
            run_steps(ns);
            exp = adv(exp, ns);
            check(lfsr_word == exp, "R5 stepped word", lfsr_word, exp);
        end

        // R5: idle enable holds the word
        held = lfsr_word;
        repeat (20) @(negedge clk);
        check(lfsr_word == held, "R5 hold without enable", lfsr_word, held);

        // R6: second strobe after lock ignored
        pulse_load();
        check(lfsr_word == held, "R6 second strobe ignored", lfsr_word, held);
        // R7: new SPI frame, then strobe again: word untouched
        spi_send(24'hABCDEF);
        check(lfsr_word == held, "R7 frame after lock ignored", lfsr_word, held);
        pulse_load();
        check(lfsr_word == held, "R6 R7 strobe with new frame ignored", lfsr_word, held);
        check(locked == 1'b1, "R9 lock sticky", {23'd0, locked}, 24'd1);

        // R4: commit with no frame ever received gives constant
        do_reset();
        pulse_load();
        check(lfsr_word == CONST_SEED, "R4 empty capture gives constant", lfsr_word, CONST_SEED);

        // R8: load lands on an enabled step clock
        do_reset();
        spi_send(24'h3C5A17);
        @(negedge clk) step_en = 1'b1;
        repeat (2) @(negedge clk);
        load_req = 1'b1;
        repeat (4) @(negedge clk);
        check(lfsr_word == 24'h3C5A17, "R8 load wins over step", lfsr_word, 24'h3C5A17);
        repeat (3) @(negedge clk);
        exp = adv(24'h3C5A17, 3);
        check(lfsr_word == exp, "R8 steps continue from seed", lfsr_word, exp);
        step_en = 1'b0; load_req = 1'b0;
        repeat (3) @(negedge clk);
        check(locked == 1'b1, "R9 lock after overlapped load", {23'd0, locked}, 24'd1);

        // R9: only reset clears the lock
        do_reset();
        check(locked == 1'b0, "R9 reset clears lock", {23'd0, locked}, 24'd0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule